// File: doc/BRIEF.md
# Multiplexed Flash Bus Cycle Decoder

This block is the device-side front end of an asynchronous flash bus where commands, addresses and data share one set of 16 I/O pins. The qualifier levels select the meaning of each cycle: chip enable (active low), command latch and address latch. The block samples the bus with its own clock. It passes the write and read strobes through two-flop synchronisers and finds their edges in logic. Each write-strobe rising edge is then classified as a command cycle, an address cycle, a data-input cycle or an illegal cycle.

Each cycle produces a one-clock strobe with its payload. A command gives a byte. An address gives a byte and its position after the last command. A data input gives a full word. A read-strobe falling edge that is qualified as a data transfer gives a read-request strobe. A data-output enable stays high while that read is held. While chip enable is high, all strobe activity is ignored so that other devices can use the same wires. A standby flag rises when the chip is deselected and the internal logic is idle.

Top module: `nand_bus_decoder`

## Requirements
- R1: A write rising edge with ce_n low, cle high, ale low and re_n high produces cmd_valid with cmd_byte = io_in[7:0]. If re_n is low, the cycle produces no strobe.
- R2: A write rising edge with ce_n low, ale high and cle low produces addr_valid with addr_byte = io_in[7:0].
- R3: addr_idx gives the number of address cycles since the last command, starting at 0. It clears on every command cycle and saturates at 7.
- R4: A write rising edge with ce_n, cle and ale all low produces data_valid with data_word = io_in[15:0].
- R5: A command cycle whose io_in[15:8] is non-zero also pulses proto_err in the same cycle as cmd_valid. The command byte is still delivered.
- R6: A write rising edge with cle and ale both high pulses illegal_cycle, and no command, address or data strobe is produced.
- R7: While ce_n is high, write and read strobe edges produce no cmd_valid, addr_valid, data_valid, illegal_cycle or rd_req.
- R8: A read falling edge with ce_n, cle and ale low pulses rd_req. out_en is high while re_n stays low with those qualifiers and we_n high, and it is low three clocks after re_n rises.
- R9: standby is high one clock after ce_n is high while lun_busy is low. It is low whenever ce_n is low or lun_busy is high.
- R10: Each output strobe lasts exactly one clock. It appears on the third rising clock edge after the bus strobe edge: two synchroniser stages plus one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch qualifier |
| ale | input | 1 | Address latch qualifier |
| we_n | input | 1 | Write strobe, active low |
| re_n | input | 1 | Read strobe, active low |
| io_in | input | 16 | Shared I/O bus |
| lun_busy | input | 1 | Internal operation in progress |
| cmd_valid | output | 1 | Command strobe |
| cmd_byte | output | 8 | Captured command |
| addr_valid | output | 1 | Address strobe |
| addr_byte | output | 8 | Captured address byte |
| addr_idx | output | 3 | Address position since last command |
| data_valid | output | 1 | Data-input strobe |
| data_word | output | 16 | Captured data word |
| rd_req | output | 1 | Data-output request strobe |
| out_en | output | 1 | Data-output enable |
| proto_err | output | 1 | Command with non-zero high byte |
| illegal_cycle | output | 1 | Both latch qualifiers high at write edge |
| standby | output | 1 | Standby may be entered |

## Verification
Directed sequences check the cases that separate the cycle types. These are: a command followed by a run of addresses long enough to reach saturation, a command issued with the read strobe low, a command with a dirty high byte, and both qualifiers high together. Deselected write and read strobes check that chip enable gates all decoding. Random qualifier and I/O combinations are then compared against a bench-side classification and a running address count. The random cases show whether any one qualifier is weighted wrongly. Read pulses under each qualifier combination separate the request strobe from the level-held output enable.

// File: rtl/nbd_pkg.sv
package nbd_pkg;

  typedef enum logic [2:0] {
    CYC_NONE,
    CYC_CMD,
    CYC_ADDR,
    CYC_DIN,
    CYC_BAD
  } wcyc_t;

  // Meaning of a write rising edge from the qualifier levels.
  function automatic wcyc_t classify_we(input logic ce_n, input logic cle,
                                        input logic ale, input logic re_n);
    wcyc_t k;
    if (ce_n)             k = CYC_NONE;
    else if (cle && ale)  k = CYC_BAD;
    else if (cle)         k = re_n ? CYC_CMD : CYC_NONE;
    else if (ale)         k = CYC_ADDR;
    else                  k = CYC_DIN;
    return k;
  endfunction

  // Saturating increment toward a limit.
  function automatic int unsigned sat_next(input int unsigned cur,
                                           input int unsigned lim);
    return (cur >= lim) ? lim : cur + 1;
  endfunction

  // Data-read qualification: selected, no latch qualifier.
  function automatic logic is_data_phase(input logic ce_n, input logic cle,
                                         input logic ale);
    return !ce_n && !cle && !ale;
  endfunction

endpackage

// File: rtl/nbd_edge_sync.sv
module nbd_edge_sync #(
  parameter int STAGES = 2,
  parameter bit RISE   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic lvl,
  output logic evt
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], strobe_n};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign lvl = sync_q[STAGES-1];

  generate
    if (RISE) begin : g_rise
      assign evt = lvl & ~last_q;
    end else begin : g_fall
      assign evt = ~lvl & last_q;
    end
  endgenerate
endmodule

// File: rtl/nbd_addr_counter.sv
module nbd_addr_counter #(
  parameter int MAX = 7,
  localparam int W = $clog2(MAX + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  output logic [W-1:0] idx
);
  import nbd_pkg::*;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (step) cnt_q <= W'(sat_next(int'(cnt_q), MAX));
  end

  assign idx = cnt_q;
endmodule

// File: rtl/nand_bus_decoder.sv
module nand_bus_decoder #(
  parameter int  IO_W      = 16,
  parameter bit  X16       = 1'b1,
  parameter int  ADDR_MAX  = 7,
  parameter int  SYNC_LEN  = 2,
  localparam int LOW_W     = 8,
  localparam int IDX_W     = $clog2(ADDR_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              cle,
  input  logic              ale,
  input  logic              we_n,
  input  logic              re_n,
  input  logic [IO_W-1:0]   io_in,
  input  logic              lun_busy,
  output logic              cmd_valid,
  output logic [LOW_W-1:0]  cmd_byte,
  output logic              addr_valid,
  output logic [LOW_W-1:0]  addr_byte,
  output logic [IDX_W-1:0]  addr_idx,
  output logic              data_valid,
  output logic [IO_W-1:0]   data_word,
  output logic              rd_req,
  output logic              out_en,
  output logic              proto_err,
  output logic              illegal_cycle,
  output logic              standby
);
  import nbd_pkg::*;

  logic [1:0] strb_n, strb_lvl, strb_evt;
  assign strb_n = {re_n, we_n};

  // Lane 0: write strobe, rising edge. Lane 1: read strobe, falling edge.
  for (genvar g = 0; g < 2; g++) begin : g_sync
    nbd_edge_sync #(.STAGES(SYNC_LEN), .RISE(g == 0)) u_sync (
      .clk(clk), .rst_n(rst_n), .strobe_n(strb_n[g]),
      .lvl(strb_lvl[g]), .evt(strb_evt[g]));
  end

  logic we_rise_evt, re_fall_evt, we_lvl, re_lvl;
  assign we_rise_evt = strb_evt[0];
  assign re_fall_evt = strb_evt[1];
  assign we_lvl      = strb_lvl[0];
  assign re_lvl      = strb_lvl[1];

  wcyc_t kind;
  assign kind = we_rise_evt ? classify_we(ce_n, cle, ale, re_n) : CYC_NONE;

  logic is_cmd, is_addr, hi_dirty, rd_phase;
  assign is_cmd   = (kind == CYC_CMD);
  assign is_addr  = (kind == CYC_ADDR);
  assign hi_dirty = X16 && (io_in[IO_W-1:LOW_W] != '0);
  assign rd_phase = is_data_phase(ce_n, cle, ale);

  logic [IDX_W-1:0] idx_now;
  nbd_addr_counter #(.MAX(ADDR_MAX)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(is_cmd), .step(is_addr), .idx(idx_now));

  logic [IO_W-1:0] data_mask;
  assign data_mask = X16 ? '1 : {{(IO_W-LOW_W){1'b0}}, {LOW_W{1'b1}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid     <= 1'b0;
      addr_valid    <= 1'b0;
      data_valid    <= 1'b0;
      illegal_cycle <= 1'b0;
      proto_err     <= 1'b0;
      rd_req        <= 1'b0;
      out_en        <= 1'b0;
      standby       <= 1'b0;
      cmd_byte      <= '0;
      addr_byte     <= '0;
      addr_idx      <= '0;
      data_word     <= '0;
    end else begin
      cmd_valid     <= is_cmd;
      addr_valid    <= is_addr;
      data_valid    <= (kind == CYC_DIN);
      illegal_cycle <= (kind == CYC_BAD);
      proto_err     <= is_cmd && hi_dirty;
      rd_req        <= re_fall_evt && rd_phase;
      out_en        <= rd_phase && !re_lvl && we_lvl;
      standby       <= ce_n && !lun_busy;
      if (is_cmd)              cmd_byte  <= io_in[LOW_W-1:0];
      if (is_addr) begin
        addr_byte <= io_in[LOW_W-1:0];
        addr_idx  <= idx_now;
      end
      if (kind == CYC_DIN)     data_word <= io_in & data_mask;
    end
  end
endmodule

// File: rtl/nbd_checker.sv
module nbd_checker #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ce_n,
  input logic             lun_busy,
  input logic             we_rise_evt,
  input logic             cmd_valid,
  input logic             addr_valid,
  input logic             data_valid,
  input logic             illegal_cycle,
  input logic             proto_err,
  input logic             rd_req,
  input logic             out_en,
  input logic             standby,
  input logic [IDX_W-1:0] addr_idx
);
  // R6: at most one classification per write edge
  p_one_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_valid, addr_valid, data_valid, illegal_cycle}));

  // R5: error flag only accompanies a command
  p_err_with_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> cmd_valid);

  // R7: every strobe came from a selected cycle
  p_ce_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid || addr_valid || data_valid || illegal_cycle || rd_req) |-> !$past(ce_n));

  // R10: write strobes follow a detected edge and last one clock
  p_from_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid || addr_valid || data_valid) |-> $past(we_rise_evt));
  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid || addr_valid || data_valid || rd_req) |=>
      !(cmd_valid || addr_valid || data_valid || rd_req));

  // R3: first address after a command starts at zero
  p_idx_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && $past(cmd_valid, 2)) |-> (addr_idx == '0));

  // R8: output enable never while deselected
  p_out_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> !$past(ce_n));

  // R9: standby only when deselected and idle
  p_standby_r9: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> ($past(ce_n) && !$past(lun_busy)));
endmodule

bind nand_bus_decoder nbd_checker #(.IDX_W(IDX_W)) u_nbd_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .lun_busy(lun_busy),
  .we_rise_evt(we_rise_evt), .cmd_valid(cmd_valid), .addr_valid(addr_valid),
  .data_valid(data_valid), .illegal_cycle(illegal_cycle), .proto_err(proto_err),
  .rd_req(rd_req), .out_en(out_en), .standby(standby), .addr_idx(addr_idx));

// File: tb/nand_bus_decoder_tb_top.sv
module nand_bus_decoder_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, ce_n, cle, ale, we_n, re_n, lun_busy;
  logic [15:0] io_in;
  logic cmd_valid, addr_valid, data_valid, rd_req, out_en, proto_err, illegal_cycle, standby;
  logic [7:0] cmd_byte, addr_byte;
  logic [2:0] addr_idx;
  logic [15:0] data_word;

  nand_bus_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
    .re_n(re_n), .io_in(io_in), .lun_busy(lun_busy), .cmd_valid(cmd_valid),
    .cmd_byte(cmd_byte), .addr_valid(addr_valid), .addr_byte(addr_byte),
    .addr_idx(addr_idx), .data_valid(data_valid), .data_word(data_word),
    .rd_req(rd_req), .out_en(out_en), .proto_err(proto_err),
    .illegal_cycle(illegal_cycle), .standby(standby));

  int total = 0;
  int bad = 0;
  int exp_cnt = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // 0 none, 1 command, 2 address, 3 data in, 4 illegal
  function automatic int bench_kind(bit c, bit cl, bit al, bit r);
    if (c) return 0;
    case ({cl, al})
      2'b11:   return 4;
      2'b10:   return r ? 1 : 0;
      2'b01:   return 2;
      default: return 3;
    endcase
  endfunction

  task automatic we_pulse(bit c, bit cl, bit al, bit r, logic [15:0] d);
    int k;
    @(negedge clk);
    ce_n = c; cle = cl; ale = al; re_n = r; io_in = d; we_n = 1'b0;
    repeat (3) @(negedge clk);
    we_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    k = bench_kind(c, cl, al, r);
    chk("R1", cmd_valid, k == 1);
    if (k == 1) chk("R1", cmd_byte, d[7:0]);
    chk("R5", proto_err, (k == 1) && (d[15:8] != 0));
    chk("R2", addr_valid, k == 2);
    if (k == 2) begin
      chk("R2", addr_byte, d[7:0]);
      chk("R3", addr_idx, exp_cnt);
      if (exp_cnt < 7) exp_cnt++;
    end
    if (k == 1) exp_cnt = 0;
    chk("R4", data_valid, k == 3);
    if (k == 3) chk("R4", data_word, d);
    chk("R6", illegal_cycle, k == 4);
    if (c) chk("R7", {cmd_valid, addr_valid, data_valid, illegal_cycle}, 0);
    @(negedge clk);
    chk("R10", {cmd_valid, addr_valid, data_valid, illegal_cycle, proto_err}, 0);
  endtask

  task automatic re_pulse(bit c, bit cl, bit al);
    bit e;
    @(negedge clk);
    re_n = 1'b1; we_n = 1'b1;
    repeat (4) @(negedge clk);
    ce_n = c; cle = cl; ale = al; re_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    e = !c && !cl && !al;
    chk(c ? "R7" : "R8", rd_req, e);
    chk("R8", out_en, e);
    @(negedge clk);
    chk("R10", rd_req, 0);
    chk("R8", out_en, e);
    re_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8", out_en, 0);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; ce_n = 1'b1; cle = 1'b0; ale = 1'b0; we_n = 1'b1; re_n = 1'b1;
    lun_busy = 1'b0; io_in = '0;
    repeat (3) @(negedge clk);
    chk("R10", {cmd_valid, addr_valid, data_valid, rd_req, out_en, proto_err, illegal_cycle, standby}, 0);
    rst_n = 1'b1;

    // R9 standby
    @(negedge clk); ce_n = 1'b1; lun_busy = 1'b0;
    @(negedge clk); chk("R9", standby, 1);
    lun_busy = 1'b1;
    @(negedge clk); chk("R9", standby, 0);
    lun_busy = 1'b0; ce_n = 1'b0;
    @(negedge clk); chk("R9", standby, 0);

    // directed
    we_pulse(0, 1, 0, 1, 16'h0070);
    for (int i = 0; i < 9; i++) we_pulse(0, 0, 1, 1, 16'h00A0 + 16'(i));
    we_pulse(0, 1, 0, 1, 16'h5A78);
    we_pulse(0, 0, 1, 1, 16'h0011);
    we_pulse(0, 1, 0, 0, 16'h0090);
    we_pulse(0, 1, 1, 1, 16'h00FF);
    we_pulse(1, 1, 0, 1, 16'h0000);
    we_pulse(1, 0, 1, 1, 16'h0033);
    we_pulse(0, 0, 0, 1, 16'hBEEF);
    we_pulse(0, 0, 1, 1, 16'h0022);
    re_pulse(0, 0, 0);
    re_pulse(1, 0, 0);
    re_pulse(0, 1, 0);
    re_pulse(0, 0, 1);

    // random
    for (int i = 0; i < 400; i++) begin
      we_pulse(($urandom % 5) == 0, $urandom % 2, $urandom % 2,
               ($urandom % 4) != 0, 16'($urandom));
    end
    for (int i = 0; i < 40; i++) begin
      re_pulse(($urandom % 4) == 0, ($urandom % 3) == 0, ($urandom % 3) == 0);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule